// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This controller sits above a byte-level I2C engine and turns one request into a whole bus transaction. It supports three operations: a presence probe of a device, a read from a byte-addressed memory behind a device, and a write to such a memory. Each request carries a 7-bit device address, a memory address of zero to four bytes and a byte count. Write data arrives on a valid/ready byte stream. Read data leaves on another valid/ready byte stream.

The engine receives one command at a time: START, STOP, write-byte or read-byte. Each command is held until the engine accepts it, and the engine answers every accepted command with one response that carries the received byte and the acknowledge level. In a read, the addressing phase is closed with a full STOP and a fresh START, never a repeated START. An optional fold mask moves memory-address bits above the sent address bytes into the low device-address bits, so that a large memory can be reached as several 256-byte devices. Bit timing, clock stretching and polling for the end of a memory write cycle are left to the engine and the host.

Top module: `i2c_mem_seq`

## Requirements
- R1: A probe (op_i=0) issues START, the write byte {dev_addr_i,1'b0}, then STOP. err_o is 1 after completion exactly when that byte was NACKed.
- R2: A read (op_i=1) with a nonzero address length first sends {dev,1'b0}. If that byte is NACKed, the sequencer issues STOP and completes with err_o=1.
- R3: Memory address bytes go out most significant first, addr_len_i of them. If any of them is NACKed, the sequencer issues STOP and completes with err_o=1.
- R4: In a read with a nonzero address length, the last address byte is followed by STOP, then START, then the write byte {dev,1'b1}.
- R5: A read with addr_len_i=0 goes from START straight to {dev,1'b1}.
- R6: Every read-byte command carries cmd_data_o[0]=0 (ACK), except the last one, which carries 1 (NACK). STOP follows the last read.
- R7: A write (op_i=2) sends the data bytes in stream order and never aborts on a NACKed data byte. It completes with fail_cnt_o equal to the number of NACKed data bytes, saturating at all ones.
- R8: The device address used is dev_addr_i | (mask & bits [6:0] of mem_addr_i shifted right by 8*addr_len_i), with the mask taken from fold_mask_i. A zero mask leaves the device address unchanged.
- R9: The acknowledge of the read-direction device byte is ignored. All data_len_i bytes are read whatever its level.
- R10: busy_o is high from the cycle after an accepted start_i until completion. done_o pulses for one cycle with busy_o low. No command is issued while idle, and start_i is ignored while busy.
- R11: Read bytes appear on rd_data_o in bus order. No read-byte command is issued while the previous byte is still waiting on the output stream.
- R12: Once cmd_valid_o is raised, it stays high with cmd_op_o and cmd_data_o unchanged until cmd_ready_i. The command encoding is 0=START, 1=STOP, 2=write byte, 3=read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a transaction (accepted only when idle) |
| op_i | input | 2 | 0 probe, 1 read, 2 write |
| dev_addr_i | input | 7 | Device address |
| mem_addr_i | input | 32 | Memory address |
| addr_len_i | input | 3 | Number of memory address bytes, 0..4 |
| data_len_i | input | 16 | Number of data bytes |
| fold_mask_i | input | 7 | Mask of high address bits merged into the device address |
| wr_data_i | input | 8 | Write data byte |
| wr_valid_i | input | 1 | Write data available |
| wr_ready_o | output | 1 | Write byte consumed |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Consumer takes the read byte |
| cmd_valid_o | output | 1 | Engine command valid |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 2 | Engine command code |
| cmd_data_o | output | 8 | Byte to send, or bit 0 = NACK for a read |
| rsp_valid_i | input | 1 | Engine finished the command |
| rsp_data_i | input | 8 | Byte received by a read command |
| rsp_nack_i | input | 1 | Acknowledge level seen (1 = NACK) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Transaction ended with an error or absent device |
| fail_cnt_o | output | 8 | NACKed write data bytes |

## Verification
The assertions check on every cycle the rules that hold regardless of the scenario: a command stays stable until it is accepted, no command appears while idle, completion comes with busy low, a write byte is consumed only when its command is accepted, a pending read byte blocks the next read command, and the failure count holds while idle. The bench scenarios show the properties that depend on order: exact command sequences for probe, read and write, the STOP/START split of a read, the ACK/NACK marking of read bytes, the abort points and their error results, counting of data NACKs, address folding, and the holding of reads under output back-pressure.

// File: rtl/i2c_mem_seq_pkg.sv
package i2c_mem_seq_pkg;
  typedef enum logic [1:0] {CMD_START = 2'd0, CMD_STOP = 2'd1, CMD_WRITE = 2'd2, CMD_READ = 2'd3} cmd_op_e;
  typedef enum logic [1:0] {XFER_PROBE = 2'd0, XFER_READ = 2'd1, XFER_WRITE = 2'd2} xfer_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  typedef enum logic [3:0] {
    PH_START, PH_DEV_WR, PH_MADDR, PH_STOP_MID, PH_START_RD,
    PH_DEV_RD, PH_RDATA, PH_WDATA, PH_STOP_END
  } phase_e;
endpackage

// File: rtl/i2c_mem_seq_fold.sv
module i2c_mem_seq_fold #(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3
) (
  input  logic [6:0]              dev_i,
  input  logic [ADDR_BYTES*8-1:0] maddr_i,
  input  logic [ALEN_W-1:0]       alen_i,
  input  logic [6:0]              mask_i,
  output logic [6:0]              dev_o
);
  localparam int AW = ADDR_BYTES * 8;
  logic [AW-1:0] hi;

  // bits left above the address bytes actually sent
  always_comb begin
    hi = '0;
    for (int b = 0; b <= ADDR_BYTES; b++)
      if (alen_i == ALEN_W'(b)) hi = (b == ADDR_BYTES) ? '0 : (maddr_i >> (8 * b));
  end

  assign dev_o = dev_i | (hi[6:0] & mask_i);
endmodule

// File: rtl/i2c_mem_seq_rdbuf.sv
module i2c_mem_seq_rdbuf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  output logic       full_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  input  logic       ready_i
);
  logic       full_q;
  logic [7:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push_i) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (full_q && ready_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o  = full_q;
  assign valid_o = full_q;
  assign data_o  = data_q;
endmodule

// File: rtl/i2c_mem_seq_ctrl.sv
module i2c_mem_seq_ctrl
  import i2c_mem_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3,
  parameter int LEN_W      = 16,
  parameter int FAIL_W     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              op_i,
  input  logic [6:0]              dev_i,
  input  logic [ADDR_BYTES*8-1:0] maddr_i,
  input  logic [ALEN_W-1:0]       alen_i,
  input  logic [LEN_W-1:0]        len_i,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [1:0]              cmd_op_o,
  output logic [7:0]              cmd_data_o,
  input  logic                    rsp_valid_i,
  input  logic                    rsp_nack_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    wr_valid_i,
  output logic                    wr_ready_o,
  input  logic                    rd_full_i,
  output logic                    rd_push_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic [FAIL_W-1:0]       fail_cnt_o
);
  state_e                  st_q;
  phase_e                  ph_q;
  xfer_e                   op_q;
  logic [6:0]              dev_q;
  logic [ADDR_BYTES*8-1:0] maddr_q;
  logic [ALEN_W-1:0]       alen_q, idx_q;
  logic [LEN_W-1:0]        rem_q;
  logic                    err_q, done_q;
  logic [FAIL_W-1:0]       fail_q;
  logic [7:0]              addr_byte;
  logic                    last_rd, rsp_ok;

  assign addr_byte = 8'(maddr_q >> {idx_q, 3'b000});
  assign last_rd   = (rem_q == LEN_W'(1));
  assign rsp_ok    = (st_q == ST_WAIT) && rsp_valid_i;

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = CMD_START;
    cmd_data_o  = '0;
    if (st_q == ST_ISSUE) begin
      unique case (ph_q)
        PH_START, PH_START_RD: cmd_valid_o = 1'b1;
        PH_STOP_MID, PH_STOP_END: begin cmd_valid_o = 1'b1; cmd_op_o = CMD_STOP; end
        PH_DEV_WR: begin cmd_valid_o = 1'b1; cmd_op_o = CMD_WRITE; cmd_data_o = {dev_q, 1'b0}; end
        PH_DEV_RD: begin cmd_valid_o = 1'b1; cmd_op_o = CMD_WRITE; cmd_data_o = {dev_q, 1'b1}; end
        PH_MADDR:  begin cmd_valid_o = 1'b1; cmd_op_o = CMD_WRITE; cmd_data_o = addr_byte; end
        PH_WDATA:  begin cmd_valid_o = wr_valid_i; cmd_op_o = CMD_WRITE; cmd_data_o = wr_data_i; end
        PH_RDATA:  begin cmd_valid_o = !rd_full_i; cmd_op_o = CMD_READ; cmd_data_o = {7'b0, last_rd}; end
        default: ;
      endcase
    end
  end

  assign wr_ready_o = (st_q == ST_ISSUE) && (ph_q == PH_WDATA) && wr_valid_i && cmd_ready_i;
  assign rd_push_o  = rsp_ok && (ph_q == PH_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_START;
      op_q    <= XFER_PROBE;
      dev_q   <= '0;
      maddr_q <= '0;
      alen_q  <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
      fail_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_ISSUE;
          ph_q    <= PH_START;
          op_q    <= xfer_e'(op_i);
          dev_q   <= dev_i;
          maddr_q <= maddr_i;
          alen_q  <= alen_i;
          rem_q   <= len_i;
          err_q   <= 1'b0;
          fail_q  <= '0;
        end
        ST_ISSUE: if (cmd_valid_o && cmd_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          st_q <= ST_ISSUE;
          unique case (ph_q)
            PH_START: ph_q <= (op_q == XFER_READ && alen_q == '0) ? PH_DEV_RD : PH_DEV_WR;
            PH_DEV_WR: begin
              if (rsp_nack_i) begin
                err_q <= 1'b1;
                ph_q  <= PH_STOP_END;
              end else if (op_q != XFER_READ && op_q != XFER_WRITE) ph_q <= PH_STOP_END;
              else if (alen_q != '0) begin
                ph_q  <= PH_MADDR;
                idx_q <= alen_q - 1'b1;
              end else ph_q <= (rem_q != '0) ? PH_WDATA : PH_STOP_END;
            end
            PH_MADDR: begin
              if (rsp_nack_i) begin
                err_q <= 1'b1;
                ph_q  <= PH_STOP_END;
              end else if (idx_q == '0) begin
                if (op_q == XFER_READ) ph_q <= PH_STOP_MID;
                else ph_q <= (rem_q != '0) ? PH_WDATA : PH_STOP_END;
              end else idx_q <= idx_q - 1'b1;
            end
            PH_STOP_MID: ph_q <= PH_START_RD;
            PH_START_RD: ph_q <= PH_DEV_RD;
            PH_DEV_RD:   ph_q <= (rem_q != '0) ? PH_RDATA : PH_STOP_END;  // ack ignored
            PH_RDATA: begin
              rem_q <= rem_q - 1'b1;
              if (last_rd) ph_q <= PH_STOP_END;
            end
            PH_WDATA: begin
              if (rsp_nack_i && fail_q != '1) fail_q <= fail_q + 1'b1;
              rem_q <= rem_q - 1'b1;
              if (last_rd) ph_q <= PH_STOP_END;
            end
            PH_STOP_END: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
            default: ph_q <= PH_STOP_END;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign fail_cnt_o = fail_q;
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 16,
  parameter int FAIL_W     = 8,
  localparam int ALEN_W    = $clog2(ADDR_BYTES + 1),
  localparam int AW        = ADDR_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [ALEN_W-1:0] addr_len_i,
  input  logic [LEN_W-1:0]  data_len_i,
  input  logic [6:0]        fold_mask_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rsp_nack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FAIL_W-1:0] fail_cnt_o
);
  logic [ALEN_W-1:0] alen_c;
  logic [6:0]        dev_f;
  logic              rd_full, rd_push;

  // lengths beyond the configured width act as the full width
  assign alen_c = (addr_len_i > ALEN_W'(ADDR_BYTES)) ? ALEN_W'(ADDR_BYTES) : addr_len_i;

  i2c_mem_seq_fold #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W)) fold_i (
    .dev_i(dev_addr_i), .maddr_i(mem_addr_i), .alen_i(alen_c), .mask_i(fold_mask_i), .dev_o(dev_f)
  );

  i2c_mem_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W), .LEN_W(LEN_W), .FAIL_W(FAIL_W)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .op_i, .dev_i(dev_f), .maddr_i(mem_addr_i), .alen_i(alen_c),
    .len_i(data_len_i), .cmd_valid_o, .cmd_ready_i, .cmd_op_o, .cmd_data_o, .rsp_valid_i,
    .rsp_nack_i, .wr_data_i, .wr_valid_i, .wr_ready_o, .rd_full_i(rd_full), .rd_push_o(rd_push),
    .busy_o, .done_o, .err_o, .fail_cnt_o
  );

  i2c_mem_seq_rdbuf rdbuf_i (
    .clk_i, .rst_ni, .push_i(rd_push), .data_i(rsp_data_i), .full_o(rd_full),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .ready_i(rd_ready_i)
  );
endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk #(
  parameter int FAIL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [1:0]        cmd_op_o,
  input logic [7:0]        cmd_data_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [7:0]        rd_data_o,
  input logic              wr_ready_o,
  input logic [FAIL_W-1:0] fail_cnt_o
);
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 2'd3 |-> !rd_valid_o); // R11
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)); // R11
  AST_WR_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd2); // R7
  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(fail_cnt_o)); // R7
endmodule

bind i2c_mem_seq i2c_mem_seq_chk #(.FAIL_W(FAIL_W)) chk_i (.*);

// File: tb/i2c_mem_seq_tb_top.sv
module i2c_mem_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        start_i = 0;
  logic [1:0]  op_i = 0;
  logic [6:0]  dev_addr_i = 0;
  logic [31:0] mem_addr_i = 0;
  logic [2:0]  addr_len_i = 0;
  logic [15:0] data_len_i = 0;
  logic [6:0]  fold_mask_i = 0;
  logic [7:0]  wr_data_i;
  logic        wr_ready_o, rd_valid_o, cmd_valid_o, busy_o, done_o, err_o;
  logic [7:0]  rd_data_o, cmd_data_o, fail_cnt_o;
  logic [1:0]  cmd_op_o;
  logic        rd_ready_i = 1;
  logic        cmd_ready_i;
  logic        rsp_valid_i, rsp_nack_i;
  logic [7:0]  rsp_data_i;

  logic        stall = 0;
  logic        log_clr = 0;
  logic [31:0] nack_mask = 0;
  logic        rdy_tog;
  int          ncmd, nrd, wcnt;
  logic [1:0]  log_op [64];
  logic [7:0]  log_dat [64];
  logic [7:0]  rd_log [64];
  int checks = 0, failures = 0;

  assign cmd_ready_i = stall ? rdy_tog : 1'b1;
  assign wr_data_i   = 8'hC0 + 8'(wcnt);

  i2c_mem_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .op_i, .dev_addr_i, .mem_addr_i, .addr_len_i,
    .data_len_i, .fold_mask_i, .wr_data_i, .wr_valid_i(1'b1), .wr_ready_o, .rd_data_o,
    .rd_valid_o, .rd_ready_i, .cmd_valid_o, .cmd_ready_i, .cmd_op_o, .cmd_data_o,
    .rsp_valid_i, .rsp_data_i, .rsp_nack_i, .busy_o, .done_o, .err_o, .fail_cnt_o
  );

  // byte engine model: one response per accepted command, one cycle later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncmd <= 0; nrd <= 0; wcnt <= 0; rdy_tog <= 0;
      rsp_valid_i <= 0; rsp_nack_i <= 0; rsp_data_i <= 0;
    end else begin
      rdy_tog     <= ~rdy_tog;
      rsp_valid_i <= cmd_valid_o && cmd_ready_i;
      if (log_clr) begin
        ncmd <= 0; nrd <= 0; wcnt <= 0;
      end else begin
        if (cmd_valid_o && cmd_ready_i) begin
          if (ncmd < 64) begin log_op[ncmd] <= cmd_op_o; log_dat[ncmd] <= cmd_data_o; end
          rsp_nack_i <= (ncmd < 32) ? nack_mask[ncmd] : 1'b0;
          rsp_data_i <= 8'h50 + 8'(ncmd);
          ncmd <= ncmd + 1;
        end
        if (rd_valid_o && rd_ready_i) begin
          if (nrd < 64) rd_log[nrd] <= rd_data_o;
          nrd <= nrd + 1;
        end
        if (wr_ready_o) wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] dev, input logic [31:0] addr,
                     input logic [2:0] alen, input logic [15:0] len, input logic [6:0] mask,
                     input logic [31:0] nk, input bit wait_end);
    @(negedge clk);
    op_i = op; dev_addr_i = dev; mem_addr_i = addr; addr_len_i = alen;
    data_len_i = len; fold_mask_i = mask; nack_mask = nk;
    log_clr = 1; start_i = 1;
    @(negedge clk);
    log_clr = 0; start_i = 0;
    if (wait_end) wait_done();
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 3000) begin @(negedge clk); t++; end
    check("R10 completion", 32'(t < 3000), 1);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  dev;
    logic [31:0] addr;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic [6:0]  mask;
    logic [31:0] nack;
    logic        err;
    logic [7:0]  fail;
    logic [7:0]  ncmd;
    logic [7:0]  dev0;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 7'h00, 32'h0,  1'b0, 8'd0, 8'd3, 8'hA0}, // R1 present
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 7'h00, 32'h2,  1'b1, 8'd0, 8'd3, 8'hA0}, // R1 absent
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd3, 7'h00, 32'h0,  1'b0, 8'd0, 8'd8, 8'hA0}, // R7 clean
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd3, 7'h00, 32'h50, 1'b0, 8'd2, 8'd8, 8'hA0}, // R7 two data NACKs
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd3, 7'h00, 32'h4,  1'b1, 8'd0, 8'd4, 8'hA0}, // R3 addr NACK
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd2, 7'h00, 32'h2,  1'b1, 8'd0, 8'd3, 8'hA0}, // R2 dev NACK
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd2, 7'h00, 32'h20, 1'b0, 8'd0, 8'd9, 8'hA0}, // R9 read dev NACK ignored
    '{2'd1, 7'h50, 32'h0,        3'd0, 8'd3, 7'h00, 32'h0,  1'b0, 8'd0, 8'd6, 8'hA1}, // R5 no addr phase
    '{2'd2, 7'h50, 32'h312,      3'd1, 8'd1, 7'h07, 32'h0,  1'b0, 8'd0, 8'd5, 8'hA6}, // R8 fold 3
    '{2'd1, 7'h50, 32'h512,      3'd1, 8'd1, 7'h03, 32'h0,  1'b0, 8'd0, 8'd8, 8'hA2}, // R8 fold masked
    '{2'd2, 7'h50, 32'hDEADBEEF, 3'd4, 8'd0, 7'h7F, 32'h0,  1'b0, 8'd0, 8'd7, 8'hA0}  // R8 nothing left to fold
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R10
    check("R10 reset busy", 32'(busy_o), 0);
    check("R10 reset cmd_valid", 32'(cmd_valid_o), 0);
    check("R10 reset done", 32'(done_o), 0);
    check("R11 reset rd_valid", 32'(rd_valid_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].op, VECS[i].dev, VECS[i].addr, VECS[i].alen, {8'h0, VECS[i].len},
          VECS[i].mask, VECS[i].nack, 1);
      check($sformatf("vec%0d err", i), 32'(err_o), 32'(VECS[i].err));
      check($sformatf("vec%0d fail", i), 32'(fail_cnt_o), 32'(VECS[i].fail));
      check($sformatf("vec%0d ncmd", i), 32'(ncmd), 32'(VECS[i].ncmd));
      check($sformatf("vec%0d devbyte", i), 32'(log_dat[1]), 32'(VECS[i].dev0));
      check($sformatf("vec%0d last STOP", i), 32'(log_op[ncmd-1]), 1);
    end

    // R3 R4 R6 R12: exact read sequence with a stalling engine
    stall = 1;
    run(2'd1, 7'h50, 32'h1234, 3'd2, 16'd2, 7'h0, 32'h0, 1);
    stall = 0;
    check("R12 count", 32'(ncmd), 10);
    check("R3 op0 START", 32'(log_op[0]), 0);
    check("R3 addr hi", 32'(log_dat[2]), 32'h12);
    check("R3 addr lo", 32'(log_dat[3]), 32'h34);
    check("R4 mid STOP", 32'(log_op[4]), 1);
    check("R4 restart", 32'(log_op[5]), 0);
    check("R4 read dev", {24'h0, log_op[6], log_dat[6]}, {24'h0, 2'd2, 8'hA1});
    check("R6 first read ACK", {24'h0, log_op[7], log_dat[7]}, {24'h0, 2'd3, 8'h00});
    check("R6 last read NACK", {24'h0, log_op[8], log_dat[8]}, {24'h0, 2'd3, 8'h01});
    check("R6 final STOP", 32'(log_op[9]), 1);
    check("R11 byte0", 32'(rd_log[0]), 32'h57);
    check("R11 byte1", 32'(rd_log[1]), 32'h58);

    // R11: output back-pressure holds the next read
    rd_ready_i = 0;
    run(2'd1, 7'h50, 32'h0, 3'd0, 16'd3, 7'h0, 32'h0, 0);
    begin
      int t = 0;
      while (!rd_valid_o && t < 500) begin @(negedge clk); t++; end
    end
    repeat (20) @(negedge clk);
    check("R11 stalled cmd count", 32'(ncmd), 3);
    check("R11 held byte", 32'(rd_data_o), 32'h52);
    check("R10 busy while stalled", 32'(busy_o), 1);
    rd_ready_i = 1;
    wait_done();
    check("R11 order b0", 32'(rd_log[0]), 32'h52);
    check("R11 order b1", 32'(rd_log[1]), 32'h53);
    check("R11 order b2", 32'(rd_log[2]), 32'h54);
    check("R11 count", 32'(nrd), 3);

    // R7: write data in stream order
    run(2'd2, 7'h50, 32'h7, 3'd1, 16'd2, 7'h0, 32'h0, 1);
    check("R3 single addr byte", 32'(log_dat[2]), 32'h07);
    check("R7 data0", {24'h0, log_op[3], log_dat[3]}, {24'h0, 2'd2, 8'hC0});
    check("R7 data1", 32'(log_dat[4]), 32'hC1);

    // R10: done pulse, idle afterwards, start ignored while busy
    run(2'd0, 7'h11, 32'h0, 3'd0, 16'd0, 7'h0, 32'h0, 0);
    check("R10 busy", 32'(busy_o), 1);
    start_i = 1; op_i = 2'd2; @(negedge clk); start_i = 0;
    wait_done();
    check("R1 probe byte", 32'(log_dat[1]), 32'h22);
    check("R10 start ignored", 32'(ncmd), 3);
    @(negedge clk);
    check("R10 done one cycle", 32'(done_o), 0);
    check("R10 idle", 32'(busy_o | cmd_valid_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule